// File: doc/BRIEF.md
# Interrupt Gate Resolver

This block turns an interrupt vector number into the entry point of its handler, following a two-level table walk in memory. Each walk starts from two base registers: one for the interrupt table and one for the global segment table. It first reads the eight-byte gate that belongs to the vector. From that gate it collects a 32-bit handler offset and a 16-bit code-segment selector. The selector then points into the global table, and the block reads that eight-byte segment descriptor to collect the segment base.

All reads go out one byte at a time through a single read port. Only one read is outstanding at any time, and the memory may take as many cycles as it needs to answer each one. When the last byte comes back, the block pulses `done` and presents three results: the selector, which is loaded into the code-segment register; the offset, which is loaded into the instruction pointer; and the linear entry address, which is the segment base plus the offset.

Privilege checks, limit checks, stack switching and gate-type decoding are not part of this block.

Top module: `int_gate_walk`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, `rd_req`, `busy` and `done` are low.
- R2: When `start` is high while the block is idle, a walk begins and the block latches `vector`, `idt_base` and `gdt_base`. When `start` is high during a walk, it has no effect on the walk.
- R3: The gate reads go to `idt_base + vector*8 + k` for k = 0 through 7, in ascending order of k. The sum wraps modulo 2^32.
- R4: `rd_req` stays high and `rd_addr` stays stable until the memory raises `rd_ack`. Each `rd_ack` pulse completes exactly one byte, and its data is taken from `rd_data` in that cycle.
- R5: The handler offset takes gate byte 0 as bits 7:0, byte 1 as bits 15:8, byte 6 as bits 23:16 and byte 7 as bits 31:24.
- R6: The selector takes gate byte 2 as bits 7:0 and gate byte 3 as bits 15:8. Gate bytes 4 and 5 are not used.
- R7: After the eighth gate byte, the descriptor reads go to `gdt_base + sel[15:3]*8 + k` for k = 0 through 7, in ascending order of k. The sum wraps modulo 2^32.
- R8: The segment base takes descriptor byte 2 as bits 7:0, byte 3 as bits 15:8, byte 4 as bits 23:16 and byte 7 as bits 31:24. Descriptor bytes 0, 1, 5 and 6 are not used.
- R9: In the cycle after the sixteenth `rd_ack`, `done` is high for exactly one cycle. At that point `entry_out` equals the segment base plus `off_out`, modulo 2^32. All three results then hold their values until the next walk begins.
- R10: While the block is idle, `rd_ack` has no effect: no request is raised and the results do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk when the block is idle |
| vector | input | VEC_W | Interrupt vector number |
| idt_base | input | AW | Base address of the interrupt gate table |
| gdt_base | input | AW | Base address of the global segment table |
| rd_req | output | 1 | Byte read request |
| rd_addr | output | AW | Byte read address |
| rd_ack | input | 1 | Read completion strobe |
| rd_data | input | 8 | Read data, valid while `rd_ack` is high |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle pulse: results are valid |
| sel_out | output | 16 | Selector destined for the code-segment register |
| off_out | output | 32 | Offset destined for the instruction pointer |
| entry_out | output | AW | Linear handler entry address |

## Verification
Most faults in the byte counter or the phase state appear at the ports within one read. A skipped, repeated or out-of-order index shows up as a wrong `rd_addr` on the very next request. If the phase state is wrong, the descriptor reads are aimed at the interrupt table instead of the global table. A byte placed in the wrong field does not appear on the address port until the descriptor phase begins, and only if the byte went into the selector. If it went into the offset or the base, the fault shows up only in the results presented with `done`. For that reason the bench checks every address and every result for every vector, and uses memory contents that differ from byte to byte.

// File: rtl/int_gate_walk.sv
module int_gate_walk #(
  parameter int VEC_W = 8,
  parameter int AW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [VEC_W-1:0] vector,
  input  logic [AW-1:0]    idt_base,
  input  logic [AW-1:0]    gdt_base,
  output logic             rd_req,
  output logic [AW-1:0]    rd_addr,
  input  logic             rd_ack,
  input  logic [7:0]       rd_data,
  output logic             busy,
  output logic             done,
  output logic [15:0]      sel_out,
  output logic [31:0]      off_out,
  output logic [AW-1:0]    entry_out
);
  localparam int ENT_SH = 3;
  localparam int IDX_W  = ENT_SH;
  localparam logic [IDX_W-1:0] LAST = '1;

  typedef enum logic [1:0] {S_IDLE, S_GATE, S_DESC} st_t;

  st_t              st;
  logic [IDX_W-1:0] idx;
  logic [VEC_W-1:0] vec_q;
  logic [AW-1:0]    idt_q, gdt_q;
  logic [31:0]      off_q, base_q;
  logic [15:0]      sel_q;
  logic             done_q;

  logic [AW-1:0] gate_at, desc_at;
  assign gate_at = idt_q + (AW'(vec_q) << ENT_SH) + AW'(idx);
  assign desc_at = gdt_q + (AW'(sel_q[15:ENT_SH]) << ENT_SH) + AW'(idx);

  assign busy      = (st != S_IDLE);
  assign rd_req    = busy;
  assign rd_addr   = (st == S_DESC) ? desc_at : gate_at;
  assign done      = done_q;
  assign sel_out   = sel_q;
  assign off_out   = off_q;
  assign entry_out = AW'(base_q) + AW'(off_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      idx    <= '0;
      vec_q  <= '0;
      idt_q  <= '0;
      gdt_q  <= '0;
      off_q  <= '0;
      sel_q  <= '0;
      base_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          vec_q <= vector;
          idt_q <= idt_base;
          gdt_q <= gdt_base;
          idx   <= '0;
          st    <= S_GATE;
        end
        S_GATE: if (rd_ack) begin
          case (idx)
            3'd0: off_q[7:0]   <= rd_data;
            3'd1: off_q[15:8]  <= rd_data;
            3'd2: sel_q[7:0]   <= rd_data;
            3'd3: sel_q[15:8]  <= rd_data;
            3'd6: off_q[23:16] <= rd_data;
            3'd7: off_q[31:24] <= rd_data;
            default: ;
          endcase
          idx <= idx + 1'b1;
          if (idx == LAST) st <= S_DESC;
        end
        S_DESC: if (rd_ack) begin
          case (idx)
            3'd2: base_q[7:0]   <= rd_data;
            3'd3: base_q[15:8]  <= rd_data;
            3'd4: base_q[23:16] <= rd_data;
            3'd7: base_q[31:24] <= rd_data;
            default: ;
          endcase
          idx <= idx + 1'b1;
          if (idx == LAST) begin
            st     <= S_IDLE;
            done_q <= 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/int_gate_walk_chk.sv
module int_gate_walk_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_req,
  input logic [AW-1:0] rd_addr,
  input logic          rd_ack,
  input logic          busy,
  input logic          done,
  input logic [AW-1:0] entry_out,
  input logic [15:0]   sel_out,
  input logic [31:0]   off_out
);
  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_ack |=> rd_req && $stable(rd_addr));

  p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && rd_ack && (rd_addr[2:0] != 3'd7) |=> rd_req && (rd_addr == $past(rd_addr) + 1'b1));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !done |=> $stable(entry_out) && $stable(sel_out) && $stable(off_out));

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !rd_req);
endmodule

bind int_gate_walk int_gate_walk_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack),
  .busy(busy), .done(done), .entry_out(entry_out), .sel_out(sel_out), .off_out(off_out)
);

// File: tb/sim_int_gate_walk.sv
`timescale 1ns/1ps
module sim_int_gate_walk;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  vector = '0;
  logic [31:0] idt_base = '0, gdt_base = '0;
  logic        rd_req, rd_ack = 1'b0, busy, done;
  logic [31:0] rd_addr, off_out, entry_out;
  logic [7:0]  rd_data = '0;
  logic [15:0] sel_out;

  int total = 0, bad = 0, cyc = 0;

  always #2.5 clk = ~clk;

  int_gate_walk u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .vector(vector),
    .idt_base(idt_base), .gdt_base(gdt_base), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_ack(rd_ack), .rd_data(rd_data), .busy(busy), .done(done),
    .sel_out(sel_out), .off_out(off_out), .entry_out(entry_out)
  );

  function automatic logic [7:0] mem(input logic [31:0] a);
    return a[7:0] ^ (a[15:8] * 8'd3) ^ (a[23:16] * 8'd5) ^ (a[31:24] * 8'd7) ^ 8'h5A;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected<190000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic serve(input logic [31:0] a, input bit inject, input int i);
    while (!rd_req) @(negedge clk);
    if (i < 8) chk("R3 gate addr", rd_addr, a);
    else       chk("R7 desc addr", rd_addr, a);
    repeat (a % 3) begin
      @(negedge clk);
      chk("R4 addr hold", {rd_req, rd_addr[30:0]}, {1'b1, a[30:0]});
    end
    rd_ack = 1'b1;
    rd_data = mem(a);
    if (inject && i == 4) begin
      start = 1'b1;
      vector = ~vector;
    end
    @(negedge clk);
    rd_ack = 1'b0;
    start = 1'b0;
  endtask

  task automatic walk(input logic [7:0] v, input logic [31:0] ib, input logic [31:0] gb, input bit inject);
    logic [31:0] g, d, off, base;
    logic [15:0] sel;
    g = ib + {21'd0, v, 3'd0};
    off  = {mem(g + 7), mem(g + 6), mem(g + 1), mem(g)};
    sel  = {mem(g + 3), mem(g + 2)};
    d = gb + {16'd0, sel[15:3], 3'd0};
    base = {mem(d + 7), mem(d + 4), mem(d + 3), mem(d + 2)};
    vector = v; idt_base = ib; gdt_base = gb;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (v[3:0] == 0) chk("R2 busy after start", busy, 1);
    for (int i = 0; i < 8; i++) serve(g + i, inject, i);
    for (int i = 0; i < 8; i++) serve(d + i, inject, i + 8);
    chk("R9 done", done, 1);
    chk("R5 offset", off_out, off);
    chk("R6 selector", sel_out, sel);
    chk("R8/R9 entry", entry_out, base + off);
    @(negedge clk);
    chk("R9 done one cycle", {busy, done}, 0);
    chk("R9 hold", entry_out, base + off);
  endtask

  initial begin
    logic [31:0] keep;
    repeat (3) @(negedge clk);
    chk("R1 reset", {rd_req, busy, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", {rd_req, busy, done}, 0);
    for (int v = 0; v < 256; v++) walk(8'(v), 32'h0001_0000, 32'h0020_0000, v % 17 == 3);
    for (int v = 192; v < 256; v++) walk(8'(v), 32'hFFFF_FF80, 32'hFFFF_C000, v % 5 == 0);
    keep = entry_out;
    rd_ack = 1'b1; rd_data = 8'hFF;
    repeat (2) @(negedge clk);
    rd_ack = 1'b0;
    chk("R10 idle ack req", {rd_req, done}, 0);
    chk("R10 idle ack entry", entry_out, keep);
    @(negedge clk);
    chk("R10 idle ack still", entry_out, keep);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule